// File: doc/BRIEF.md
# Single-Unit Memory Transfer Engine

This block performs exactly one transfer unit for each start pulse. It reads a halfword or a word from a source address and writes it to a destination address over a simple valid/ready memory port. It then works out the addresses and remaining count for the following unit, and it reports how many bus cycles the unit cost. A surrounding channel controller owns the channel registers, chooses which channel runs and raises interrupts. It feeds the working addresses, step modes, width, count and a first-unit flag into this engine, and on the done pulse it takes back the updated values.

The cost of a unit comes from per-region wait-state tables that live outside the block. While a unit is in flight, the engine presents the memory region of each address, whether the access counts as sequential, and the unit width on lookup outputs. The wait values for source and destination come back combinationally. A source address of zero has a special meaning: no read is made, and the engine writes again the value held in its internal transfer latch.

Top module: `xfer_unit_engine`

## Requirements
- R1: `wide`=1 selects a 4-byte unit and `wide`=0 a 2-byte unit. `mem_wide` carries the captured width on both accesses of the unit. A 2-byte read keeps only `mem_rdata[15:0]`, and the written word has zero in its upper halfword.
- R2: Step codes are 0 = increment, 1 = decrement, 2 = hold, 3 = increment (the reload variant is handled by the caller). `next_src` and `next_dst` equal the captured address plus, minus or plus zero the unit size in bytes.
- R3: Cost equals 2 + source wait + destination wait. During a unit, `lk_src_region`/`lk_dst_region` are address bits [27:24], `lk_seq` is the inverse of the captured first-unit flag, and `lk_wide` is the captured width.
- R4: When `first_unit`=1, both addresses are aligned down to the unit size before use. Two extra cycles are added if either aligned address is below `CART_BASE` (default 0x08000000). With `first_unit`=0, the addresses are used unaligned and no extra cycles are added.
- R5: An aligned source address of zero issues no read. The write carries the current latch contents, and `next_src` stays zero.
- R6: After a 4-byte unit, the latch's upper halfword is copied into its lower halfword. After a 2-byte unit, the lower halfword is copied into the upper halfword. The next zero-source unit writes that merged value.
- R7: `next_count` is the captured count minus one, and `last` is 1 exactly when that result is zero.
- R8: The read comes before the write, and read data is captured on the read handshake. While `mem_valid`=1 and `mem_ready`=0, the request stays unchanged.
- R9: `done` is a one-cycle pulse on which all result outputs are valid. Without stalls, `done` appears 3 cycles after the start edge, or 2 cycles when the source is zero. A `start` asserted while a unit is in flight is ignored.
- R10: After synchronous reset, no request is active, `done`, `last`, `cost` and `next_count` are zero, and the latch holds zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one unit (sampled only when idle) |
| wide | input | 1 | 1 = 4-byte unit, 0 = 2-byte unit |
| src_mode | input | 2 | Source step code |
| dst_mode | input | 2 | Destination step code |
| src_addr | input | AW | Working source address |
| dst_addr | input | AW | Working destination address |
| count_in | input | CW | Units remaining including this one |
| first_unit | input | 1 | This unit opens a run |
| lk_src_region | output | RW | Source region index for the wait lookup |
| lk_dst_region | output | RW | Destination region index for the wait lookup |
| lk_seq | output | 1 | Lookup selects sequential waits |
| lk_wide | output | 1 | Lookup selects the 32-bit table |
| src_wait | input | WW | Looked-up source wait cycles |
| dst_wait | input | WW | Looked-up destination wait cycles |
| mem_valid | output | 1 | Memory request valid |
| mem_write | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | Access size, 1 = word |
| mem_addr | output | AW | Access address |
| mem_wdata | output | DW | Write data |
| mem_ready | input | 1 | Memory accepts the request |
| mem_rdata | input | DW | Read data, valid with the read handshake |
| next_src | output | AW | Source address for the next unit |
| next_dst | output | AW | Destination address for the next unit |
| next_count | output | CW | Remaining count after this unit |
| cost | output | CSTW | Bus cycles charged to this unit |
| last | output | 1 | Remaining count reached zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest state to reach from the ports is the halfword-merged contents of the transfer latch. The latch can only be seen through a zero-source unit, and what it holds depends on the width of the unit that ran before. The stimulus therefore runs a 4-byte unit from a known address, then a 2-byte zero-source unit, then a 4-byte zero-source unit. The data on each zero-source write shows the merge rule that applied to the latch. A second case that is hard to reach is a start pulse arriving while a stalled unit is in flight. It is covered by holding `mem_ready` low for several cycles per access while `start` is raised again with different inputs.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    STEP_UP     = 2'd0,
    STEP_DOWN   = 2'd1,
    STEP_HOLD   = 2'd2,
    STEP_UP_RLD = 2'd3
  } step_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/xfer_addr_step.sv
module xfer_addr_step
  import xfer_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  step_e         mode,
  input  logic          wide,
  input  logic          freeze,
  output logic [AW-1:0] next
);
  logic [AW-1:0] size_b;

  always_comb begin
    size_b = wide ? AW'(4) : AW'(2);
    if (freeze) begin
      next = addr;
    end else begin
      case (mode)
        STEP_DOWN: next = addr - size_b;
        STEP_HOLD: next = addr;
        default:   next = addr + size_b;
      endcase
    end
  end
endmodule

// File: rtl/xfer_cost_calc.sv
module xfer_cost_calc #(
  parameter int          AW        = 32,
  parameter int          WW        = 4,
  parameter int          CSTW      = 8,
  parameter logic [31:0] CART_BASE = 32'h0800_0000
) (
  input  logic [AW-1:0]   src,
  input  logic [AW-1:0]   dst,
  input  logic            first,
  input  logic [WW-1:0]   src_wait,
  input  logic [WW-1:0]   dst_wait,
  output logic [CSTW-1:0] cost
);
  localparam logic [AW-1:0] BOUND = AW'(CART_BASE);

  logic low_region;

  always_comb begin
    low_region = (src < BOUND) || (dst < BOUND);
    cost = CSTW'(2) + CSTW'(src_wait) + CSTW'(dst_wait)
         + ((first && low_region) ? CSTW'(2) : CSTW'(0));
  end
endmodule

// File: rtl/xfer_unit_engine.sv
module xfer_unit_engine
  import xfer_pkg::*;
#(
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          CW        = 17,
  parameter int          WW        = 4,
  parameter int          CSTW      = 8,
  parameter int          RW        = 4,
  parameter int          REG_LSB   = 24,
  parameter logic [31:0] CART_BASE = 32'h0800_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            wide,
  input  logic [1:0]      src_mode,
  input  logic [1:0]      dst_mode,
  input  logic [AW-1:0]   src_addr,
  input  logic [AW-1:0]   dst_addr,
  input  logic [CW-1:0]   count_in,
  input  logic            first_unit,
  output logic [RW-1:0]   lk_src_region,
  output logic [RW-1:0]   lk_dst_region,
  output logic            lk_seq,
  output logic            lk_wide,
  input  logic [WW-1:0]   src_wait,
  input  logic [WW-1:0]   dst_wait,
  output logic            mem_valid,
  output logic            mem_write,
  output logic            mem_wide,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic            mem_ready,
  input  logic [DW-1:0]   mem_rdata,
  output logic [AW-1:0]   next_src,
  output logic [AW-1:0]   next_dst,
  output logic [CW-1:0]   next_count,
  output logic [CSTW-1:0] cost,
  output logic            last,
  output logic            done
);
  localparam int HW = DW / 2;
  localparam logic [AW-1:0] MASK_W = ~AW'(3);
  localparam logic [AW-1:0] MASK_H = ~AW'(1);

  xfer_state_e   state_q;
  logic [AW-1:0] addr_q [2];
  step_e         mode_q [2];
  logic          wide_q, first_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] latch_q;
  logic [AW-1:0] nsrc_q, ndst_q;
  logic [CW-1:0] ncnt_q;
  logic [CSTW-1:0] cost_q;
  logic          last_q, done_q;

  logic [AW-1:0] src_al, dst_al;
  logic [AW-1:0] step_next [2];
  logic          src_zero;
  logic [CSTW-1:0] cost_w;

  always_comb begin
    src_al = first_unit ? (src_addr & (wide ? MASK_W : MASK_H)) : src_addr;
    dst_al = first_unit ? (dst_addr & (wide ? MASK_W : MASK_H)) : dst_addr;
    src_zero = (addr_q[0] == '0);
  end

  for (genvar p = 0; p < 2; p++) begin : g_step
    xfer_addr_step #(.AW(AW)) u_step (
      .addr   (addr_q[p]),
      .mode   (mode_q[p]),
      .wide   (wide_q),
      .freeze ((p == 0) ? src_zero : 1'b0),
      .next   (step_next[p])
    );
  end

  xfer_cost_calc #(
    .AW(AW), .WW(WW), .CSTW(CSTW), .CART_BASE(CART_BASE)
  ) u_cost (
    .src      (addr_q[0]),
    .dst      (addr_q[1]),
    .first    (first_q),
    .src_wait (src_wait),
    .dst_wait (dst_wait),
    .cost     (cost_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      addr_q[0] <= '0;
      addr_q[1] <= '0;
      mode_q[0] <= STEP_UP;
      mode_q[1] <= STEP_UP;
      wide_q  <= 1'b0;
      first_q <= 1'b0;
      cnt_q   <= '0;
      latch_q <= '0;
      nsrc_q  <= '0;
      ndst_q  <= '0;
      ncnt_q  <= '0;
      cost_q  <= '0;
      last_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            addr_q[0] <= src_al;
            addr_q[1] <= dst_al;
            mode_q[0] <= step_e'(src_mode);
            mode_q[1] <= step_e'(dst_mode);
            wide_q  <= wide;
            first_q <= first_unit;
            cnt_q   <= count_in;
            state_q <= (src_al == '0) ? ST_WRITE : ST_READ;
          end
        end
        ST_READ: begin
          if (mem_ready) begin
            latch_q <= wide_q ? mem_rdata : {{HW{1'b0}}, mem_rdata[HW-1:0]};
            state_q <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (mem_ready) begin
            latch_q <= wide_q ? {latch_q[DW-1:HW], latch_q[DW-1:HW]}
                              : {latch_q[HW-1:0], latch_q[HW-1:0]};
            nsrc_q  <= step_next[0];
            ndst_q  <= step_next[1];
            ncnt_q  <= cnt_q - CW'(1);
            last_q  <= (cnt_q == CW'(1));
            cost_q  <= cost_w;
            done_q  <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    lk_src_region = addr_q[0][REG_LSB +: RW];
    lk_dst_region = addr_q[1][REG_LSB +: RW];
    lk_seq    = ~first_q;
    lk_wide   = wide_q;
    mem_valid = (state_q != ST_IDLE);
    mem_write = (state_q == ST_WRITE);
    mem_wide  = wide_q;
    mem_addr  = (state_q == ST_WRITE) ? addr_q[1] : addr_q[0];
    mem_wdata = latch_q;
    next_src   = nsrc_q;
    next_dst   = ndst_q;
    next_count = ncnt_q;
    cost = cost_q;
    last = last_q;
    done = done_q;
  end
endmodule

// File: rtl/xfer_unit_engine_chk.sv
module xfer_unit_engine_chk #(
  parameter int AW = 32,
  parameter int CW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_valid,
  input logic          mem_write,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic          done,
  input logic          last,
  input logic [CW-1:0] next_count
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));

  assert_read_then_write_R8: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && !mem_write) |=> (mem_valid && mem_write));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_valid);

  assert_last_flag_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (last == (next_count == '0)));

  assert_no_zero_read_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_write) |-> (mem_addr != '0));
endmodule

bind xfer_unit_engine xfer_unit_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mem_valid  (mem_valid),
  .mem_write  (mem_write),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .done       (done),
  .last       (last),
  .next_count (next_count)
);

// File: tb/xfer_unit_engine_test.sv
module xfer_unit_engine_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0, wide = 1'b0, first_unit = 1'b0;
  logic [1:0]  src_mode = 2'd0, dst_mode = 2'd0;
  logic [31:0] src_addr = '0, dst_addr = '0;
  logic [16:0] count_in = '0;
  logic [3:0]  lk_src_region, lk_dst_region;
  logic        lk_seq, lk_wide;
  logic [3:0]  src_wait, dst_wait;
  logic        mem_valid, mem_write, mem_wide, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] next_src, next_dst;
  logic [16:0] next_count;
  logic [7:0]  cost;
  logic        last, done;

  int n_chk = 0, n_fail = 0;
  logic stall_en = 1'b0;
  int   stall_ctr = 0;
  int   rd_cnt = 0;
  logic [31:0] rd_addr = '0, wr_addr = '0, wr_data = '0;
  logic        wr_wide = 1'b0;

  always #10 clk = ~clk;

  xfer_unit_engine uut (
    .clk(clk), .rst(rst), .start(start), .wide(wide),
    .src_mode(src_mode), .dst_mode(dst_mode),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .count_in(count_in), .first_unit(first_unit),
    .lk_src_region(lk_src_region), .lk_dst_region(lk_dst_region),
    .lk_seq(lk_seq), .lk_wide(lk_wide),
    .src_wait(src_wait), .dst_wait(dst_wait),
    .mem_valid(mem_valid), .mem_write(mem_write), .mem_wide(mem_wide),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .next_src(next_src), .next_dst(next_dst), .next_count(next_count),
    .cost(cost), .last(last), .done(done)
  );

  function automatic logic [31:0] mdata(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  // wait table model: region low bits + 2 if nonsequential + 1 if word
  function automatic logic [3:0] wt(input logic [3:0] r, input logic sq, input logic w);
    return {2'b00, r[1:0]} + (sq ? 4'd0 : 4'd2) + (w ? 4'd1 : 4'd0);
  endfunction

  always_comb begin
    src_wait  = wt(lk_src_region, lk_seq, lk_wide);
    dst_wait  = wt(lk_dst_region, lk_seq, lk_wide);
    mem_ready = mem_valid && (!stall_en || stall_ctr == 3);
    mem_rdata = mdata(mem_addr);
  end

  always @(posedge clk) begin
    if (mem_valid && !mem_ready) stall_ctr <= stall_ctr + 1;
    else stall_ctr <= 0;
    if (mem_valid && mem_ready && !mem_write) begin
      rd_cnt  <= rd_cnt + 1;
      rd_addr <= mem_addr;
    end
    if (mem_valid && mem_ready && mem_write) begin
      wr_addr <= mem_addr;
      wr_data <= mem_wdata;
      wr_wide <= mem_wide;
    end
  end

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic        w;
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic        f;
    logic [31:0] s;
    logic [31:0] d;
    logic [16:0] c;
    logic [31:0] es;
    logic [31:0] ed;
    logic [16:0] ec;
    logic [7:0]  ecost;
    logic        elast;
  } vec_t;

  localparam vec_t VEC [5] = '{
    '{1'b1, 2'd0, 2'd0, 1'b1, 32'h0200_0003, 32'h0600_0006, 17'd4,
      32'h0200_0004, 32'h0600_0008, 17'd3, 8'd14, 1'b0},
    '{1'b0, 2'd1, 2'd2, 1'b0, 32'h0300_0010, 32'h0500_0020, 17'd1,
      32'h0300_000E, 32'h0500_0020, 17'd0, 8'd6, 1'b1},
    '{1'b0, 2'd3, 2'd3, 1'b1, 32'h0800_0101, 32'h0E00_0003, 17'h10000,
      32'h0800_0102, 32'h0E00_0004, 17'h0FFFF, 8'd8, 1'b0},
    '{1'b1, 2'd2, 2'd1, 1'b0, 32'h0A00_0008, 32'h0300_0100, 17'd2,
      32'h0A00_0008, 32'h0300_00FC, 17'd1, 8'd9, 1'b0},
    '{1'b1, 2'd0, 2'd0, 1'b1, 32'h0900_0000, 32'h07FF_FFFC, 17'd3,
      32'h0900_0004, 32'h0800_0000, 17'd2, 8'd14, 1'b0}
  };

  task automatic run_unit(input logic w, input logic [1:0] sm, input logic [1:0] dm,
                          input logic f, input logic [31:0] s, input logic [31:0] d,
                          input logic [16:0] c, input logic poke, output int lat);
    @(negedge clk);
    wide = w; src_mode = sm; dst_mode = dm; first_unit = f;
    src_addr = s; dst_addr = d; count_in = c; start = 1'b1;
    @(negedge clk);
    lat = 1;
    if (poke) begin
      src_addr = 32'h0B00_0040; dst_addr = 32'h0C00_0080;
      count_in = 17'd9; wide = ~w; first_unit = 1'b1;
    end else begin
      start = 1'b0;
    end
    while (!done && lat < 60) begin
      @(negedge clk);
      start = 1'b0;
      lat++;
    end
  endtask

  initial begin
    #3000000;
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lat;
    int rd0;
    logic [31:0] sal, dal, exp_wd;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10", "mem_valid", 64'(mem_valid), 64'd0);
    check("R10", "done", 64'(done), 64'd0);
    check("R10", "last", 64'(last), 64'd0);
    check("R10", "cost", 64'(cost), 64'd0);
    check("R10", "next_count", 64'(next_count), 64'd0);

    // R10: zero-source unit right after reset writes the reset latch value
    run_unit(1'b1, 2'd0, 2'd0, 1'b1, 32'h0, 32'h0400_0000, 17'd1, 1'b0, lat);
    check("R10", "latch after reset", 64'(wr_data), 64'd0);

    for (int i = 0; i < 5; i++) begin
      rd0 = rd_cnt;
      run_unit(VEC[i].w, VEC[i].sm, VEC[i].dm, VEC[i].f, VEC[i].s, VEC[i].d,
               VEC[i].c, 1'b0, lat);
      sal = VEC[i].f ? (VEC[i].s & (VEC[i].w ? ~32'd3 : ~32'd1)) : VEC[i].s;
      dal = VEC[i].f ? (VEC[i].d & (VEC[i].w ? ~32'd3 : ~32'd1)) : VEC[i].d;
      exp_wd = VEC[i].w ? mdata(sal) : {16'h0000, mdata(sal)[15:0]};
      check("R9", "latency", 64'(lat), 64'd3);
      check("R4", "read address", 64'(rd_addr), 64'(sal));
      check("R4", "write address", 64'(wr_addr), 64'(dal));
      check("R8", "one read", 64'(rd_cnt - rd0), 64'd1);
      check("R1", "write data", 64'(wr_data), 64'(exp_wd));
      check("R1", "mem_wide", 64'(wr_wide), 64'(VEC[i].w));
      check("R2", "next_src", 64'(next_src), 64'(VEC[i].es));
      check("R2", "next_dst", 64'(next_dst), 64'(VEC[i].ed));
      check("R7", "next_count", 64'(next_count), 64'(VEC[i].ec));
      check("R7", "last", 64'(last), 64'(VEC[i].elast));
      check("R3", "cost", 64'(cost), 64'(VEC[i].ecost));
      @(negedge clk);
      check("R9", "done pulse width", 64'(done), 64'd0);
    end

    // R5/R6: narrow zero-source unit after the word unit from 0x09000000
    rd0 = rd_cnt;
    run_unit(1'b0, 2'd0, 2'd0, 1'b1, 32'h0, 32'h0200_0010, 17'd5, 1'b0, lat);
    check("R5", "no read", 64'(rd_cnt - rd0), 64'd0);
    check("R9", "zero-source latency", 64'(lat), 64'd2);
    check("R6", "word merge upper->lower", 64'(wr_data[15:0]), 64'h5A5A);
    check("R5", "source held", 64'(next_src), 64'd0);
    check("R5", "dest stepped", 64'(next_dst), 64'h0200_0012);
    check("R4", "cost zero source", 64'(cost), 64'd10);

    // R6: word zero-source unit after narrow unit
    rd0 = rd_cnt;
    run_unit(1'b1, 2'd2, 2'd1, 1'b0, 32'h0, 32'h0200_0020, 17'd1, 1'b0, lat);
    check("R5", "no read word", 64'(rd_cnt - rd0), 64'd0);
    check("R6", "halfword merge lower->upper", 64'(wr_data), 64'h5A5A_5A5A);
    check("R2", "dest decrement", 64'(next_dst), 64'h0200_001C);
    check("R3", "cost sequential", 64'(cost), 64'd6);
    check("R7", "last at one", 64'(last), 64'd1);

    // R8/R9: stalled memory with a start raised mid-unit
    stall_en = 1'b1;
    rd0 = rd_cnt;
    run_unit(VEC[1].w, VEC[1].sm, VEC[1].dm, VEC[1].f, VEC[1].s, VEC[1].d,
             VEC[1].c, 1'b1, lat);
    check("R8", "stalled latency", 64'(lat), 64'd9);
    check("R9", "busy start ignored src", 64'(next_src), 64'(VEC[1].es));
    check("R9", "busy start ignored count", 64'(next_count), 64'(VEC[1].ec));
    check("R8", "stalled one read", 64'(rd_cnt - rd0), 64'd1);
    check("R3", "stalled cost", 64'(cost), 64'(VEC[1].ecost));
    stall_en = 1'b0;
    repeat (3) @(negedge clk);
    check("R9", "no second unit", 64'(mem_valid), 64'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule